// File: doc/BRIEF.md
# Serial Control Frame Receiver for a Two-Channel Audio Processor

This block takes control words for a stereo volume and tone processor from a three-wire serial link made of a select line, a serial clock and a data line. While the select line is high, each rising serial clock edge shifts one data bit into a 52-bit frame. The first eight bits of the frame are an address. The next 44 bits are a data word. When the select line falls, the block examines the frame. If the frame is well formed, the block commits the data word into the left channel register, the right channel register, or both. A two-bit field inside the data word chooses which.

All three link inputs pass through two-flop synchronisers, and their edges are detected in the system clock domain. The system clock must be many times faster than the serial clock. After reset, the block refuses normal frames until it has received an initialisation frame. That frame carries its own address and a data word of all zeros. A mute request output stays high until the first normal frame has been committed. Each channel register has a one-cycle update strobe. The strobes are plain outputs with no back-pressure: a consumer must sample the registers when it sees a strobe, and the block never waits for it.

Top module: `serctl_rx`

## Requirements
- R1: After reset, both channel words are zero, `init_done` is 0, `mute_req` is 1, and both update strobes are 0.
- R2: Before an initialisation frame has been accepted, a frame that carries the normal address changes neither channel word and raises no strobe.
- R3: A frame with address INIT_ADDR (default 8'b1000_0001) and a data word of all zeros sets `init_done`. It writes zero to both channel words and strobes both. A frame with the same address and any data bit set is ignored. `init_done` never falls until reset.
- R4: Bits are taken on rising serial clock edges while the select line is high, least significant bit first. Frame bits 0..7 are address bits 0..7, and frame bits 8..51 are data bits D0..D43. The commit happens only when the select line falls.
- R5: When the select line falls after any number of bits other than exactly 52, whether fewer or more, the frame is discarded. Serial clock edges while the select line is low are not counted.
- R6: A frame whose address equals neither INIT_ADDR nor NORM_ADDR (default 8'h41) is ignored.
- R7: A normal frame with any of data bits D36, D37, D38, D40, D41, D42 or D43 set is ignored. Bit D39 is not reserved.
- R8: Data bits D35:D34 select the target of a normal frame. The code 2'b01 writes the left word only, 2'b10 writes the right word only, and 2'b11 or 2'b00 writes both. The full 44-bit data word is stored.
- R9: Each channel word that is written raises its own strobe for exactly one cycle, in the same cycle the new value appears.
- R10: `mute_req` falls when the first normal frame is committed and stays low until reset. It is never low while `init_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs | input | 1 | Serial select; frame window while high, commit on fall |
| ser_clk | input | 1 | Serial bit clock, data taken on rising edge |
| ser_dat | input | 1 | Serial data |
| left_word | output | 44 | Committed left channel control word |
| right_word | output | 44 | Committed right channel control word |
| left_upd | output | 1 | One-cycle strobe when the left word is written |
| right_upd | output | 1 | One-cycle strobe when the right word is written |
| init_done | output | 1 | Initialisation frame has been accepted |
| mute_req | output | 1 | High until the first normal frame is committed |

## Verification
Most internal faults in this block show up at the ports within a few system cycles of the select line falling. A bad bit counter or a bad shift order gives wrong or bit-reversed words, or loses a commit. A bad gate on the address, the reserved bits or the initialisation rule leaves a word changed that should have held, together with a stray strobe. For this reason every frame, whether directed or random, is followed by a comparison of both words, both flags and the number of strobes that frame produced. A fault in the sticky flags, `init_done` and `mute_req`, appears only on a later frame, so these flags are rechecked after every frame.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  typedef enum logic [1:0] {
    CS_INIT  = 2'b00,
    CS_LEFT  = 2'b01,
    CS_RIGHT = 2'b10,
    CS_BOTH  = 2'b11
  } chan_sel_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st[0] <= d_in;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign d_out = st[STAGES-1];
endmodule

// File: rtl/serctl_deser.sv
module serctl_deser #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 44
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs,
  input  logic                       sck,
  input  logic                       sd,
  output logic                       frame_stb,
  output logic [ADDR_W+DATA_W-1:0]   frame
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               cs_q, sck_q;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sr;
  logic               sck_rise, cs_fall;

  assign sck_rise = sck & ~sck_q;
  assign cs_fall  = cs_q & ~cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b0;
      sck_q <= 1'b0;
      cnt   <= '0;
      sr    <= '0;
    end else begin
      cs_q  <= cs;
      sck_q <= sck;
      if (!cs) begin
        cnt <= '0;
      end else if (sck_rise) begin
        sr <= {sd, sr[FRAME_W-1:1]};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame_stb = cs_fall && (cnt == CNT_FULL);
  assign frame     = sr;

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_SAT);
  // R5
  cnt_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> (cnt == '0));
endmodule

// File: rtl/serctl_bank.sv
module serctl_bank #(
  parameter int DATA_W = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic              upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      upd <= 1'b0;
    end else begin
      upd <= wr;
      if (wr) q <= din;
    end
  end

  // R9
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
endmodule

// File: rtl/serctl_rx.sv
module serctl_rx #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 44,
  parameter logic [7:0]  INIT_ADDR = 8'b1000_0001,
  parameter logic [7:0]  NORM_ADDR = 8'h41,
  parameter int          CSEL_LO   = 34,
  parameter logic [43:0] RSV_MASK  = 44'hF7000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_cs,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [DATA_W-1:0] left_word,
  output logic [DATA_W-1:0] right_word,
  output logic              left_upd,
  output logic              right_upd,
  output logic              init_done,
  output logic              mute_req
);
  import serctl_pkg::*;

  localparam int FRAME_W = ADDR_W + DATA_W;

  logic [2:0]         sync_o;
  logic               frame_stb;
  logic [FRAME_W-1:0] frame;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  data;
  logic               is_init, is_norm;
  chan_sel_e          sel;
  logic [NUM_CH-1:0]  wr;
  logic [DATA_W-1:0]  word [NUM_CH];
  logic [NUM_CH-1:0]  upd;

  serctl_sync #(.W(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({ser_cs, ser_clk, ser_dat}),
    .d_out (sync_o)
  );

  serctl_deser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (sync_o[2]),
    .sck       (sync_o[1]),
    .sd        (sync_o[0]),
    .frame_stb (frame_stb),
    .frame     (frame)
  );

  assign addr    = frame[ADDR_W-1:0];
  assign data    = frame[FRAME_W-1:ADDR_W];
  assign sel     = chan_sel_e'(data[CSEL_LO +: 2]);
  assign is_init = (addr == ADDR_W'(INIT_ADDR)) && (data == '0);
  assign is_norm = (addr == ADDR_W'(NORM_ADDR)) && init_done &&
                   ((data & DATA_W'(RSV_MASK)) == '0);

  assign wr[0] = frame_stb && (is_init || (is_norm && sel != CS_RIGHT));
  assign wr[1] = frame_stb && (is_init || (is_norm && sel != CS_LEFT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done <= 1'b0;
      mute_req  <= 1'b1;
    end else begin
      if (frame_stb && is_init) init_done <= 1'b1;
      if (frame_stb && is_norm) mute_req  <= 1'b0;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
    serctl_bank #(.DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr[ch]),
      .din   (data),
      .q     (word[ch]),
      .upd   (upd[ch])
    );
  end

  assign left_word  = word[0];
  assign right_word = word[1];
  assign left_upd   = upd[0];
  assign right_upd  = upd[1];

  // R3
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R10
  mute_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_req |=> !mute_req);
  // R10
  mute_needs_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_req |-> init_done);
  // R2
  no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> ($stable(left_word) && $stable(right_word)));
  // R7
  rsv_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && addr == ADDR_W'(NORM_ADDR) && (data & DATA_W'(RSV_MASK)) != '0)
      |=> (!left_upd && !right_upd));
endmodule

// File: tb/serctl_rx_test.sv
module serctl_rx_test;
  localparam logic [7:0]  INIT_A = 8'b1000_0001;
  localparam logic [7:0]  NORM_A = 8'h41;
  localparam logic [43:0] RSV    = 44'hF7000000000;
  localparam int          P      = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_cs = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [43:0] left_word, right_word;
  logic left_upd, right_upd, init_done, mute_req;

  int nchk = 0, nbad = 0, sl = 0, sr = 0;
  logic [43:0] eL = '0, eR = '0;
  logic eRdy = 1'b0, eMute = 1'b1;
  bit finished = 0;

  always #2 clk = ~clk;

  serctl_rx uut (
    .clk(clk), .rst_n(rst_n), .ser_cs(ser_cs), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .left_word(left_word), .right_word(right_word), .left_upd(left_upd),
    .right_upd(right_upd), .init_done(init_done), .mute_req(mute_req)
  );

  always @(negedge clk) begin
    if (left_upd)  sl++;
    if (right_upd) sr++;
  end

  task automatic chk(input string req, input string what, input logic [43:0] act, input logic [43:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] a, input logic [43:0] d, input int nbits);
    logic [51:0] v;
    v = {d, a};
    ser_cs = 1'b1;
    wait_n(P);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 52) ? v[i] : 1'($urandom);
      wait_n(P);
      ser_clk = 1'b1;
      wait_n(P);
      ser_clk = 1'b0;
    end
    wait_n(P);
    ser_cs = 1'b0;
    wait_n(10);
  endtask

  task automatic frame(input string req, input logic [7:0] a, input logic [43:0] d, input int nbits);
    int l0, r0, dl, dr;
    l0 = sl; r0 = sr; dl = 0; dr = 0;
    send(a, d, nbits);
    if (nbits == 52) begin
      if (a == INIT_A && d == '0) begin
        eL = '0; eR = '0; eRdy = 1'b1; dl = 1; dr = 1;
      end else if (a == NORM_A && eRdy && (d & RSV) == '0) begin
        if (d[35:34] != 2'b10) begin eL = d; dl = 1; end
        if (d[35:34] != 2'b01) begin eR = d; dr = 1; end
        eMute = 1'b0;
      end
    end
    chk(req, "left_word", left_word, eL);
    chk(req, "right_word", right_word, eR);
    chk(req, "init_done", 44'(init_done), 44'(eRdy));
    chk(req, "mute_req", 44'(mute_req), 44'(eMute));
    chk(req, "left strobes", 44'(sl - l0), 44'(dl));
    chk(req, "right strobes", 44'(sr - r0), 44'(dr));
  endtask

  function automatic logic [43:0] rnd44();
    return {12'($urandom), 32'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wait_n(3);
    // R1 reset state
    chk("R1", "left_word", left_word, '0);
    chk("R1", "right_word", right_word, '0);
    chk("R1", "init_done", 44'(init_done), 44'd0);
    chk("R1", "mute_req", 44'(mute_req), 44'd1);
    chk("R1", "strobes", 44'({left_upd, right_upd}), 44'd0);
    rst_n = 1'b1;
    wait_n(3);
    // R2 normal frame before init
    frame("R2", NORM_A, 44'h0_1234_5678, 52);
    // R3 init address with nonzero data rejected
    frame("R3", INIT_A, 44'h000_0000_0100, 52);
    // R5 short init frame
    frame("R5", INIT_A, '0, 51);
    // R3 init frame accepted, R9 strobes both
    frame("R3", INIT_A, '0, 52);
    // R4 bit order: D0 set, left only (D35:D34=01) ; R8 R10
    frame("R4", NORM_A, 44'h004_0000_0001, 52);
    // R8 right only
    frame("R8", NORM_A, 44'h008_ABCD_0002, 52);
    // R8 both with code 11
    frame("R8", NORM_A, 44'h00C_5555_AAAA, 52);
    // R8 both with code 00
    frame("R8", NORM_A, 44'h003_1357_9BDF, 52);
    // R7 each reserved bit rejected
    foreach (RSV[b]) if (RSV[b]) frame("R7", NORM_A, 44'h004_0000_00FF | (44'd1 << b), 52);
    // R7 bit D39 is not reserved
    frame("R7", NORM_A, 44'h08C_0000_0F0F, 52);
    // R6 foreign address
    frame("R6", 8'h42, 44'h004_1111_1111, 52);
    // R5 over-long frame
    frame("R5", NORM_A, 44'h004_2222_2222, 53);
    // R5 serial clocks while select is low are not counted
    for (int i = 0; i < 5; i++) begin
      ser_clk = 1'b1; wait_n(P); ser_clk = 1'b0; wait_n(P);
    end
    frame("R5", NORM_A, 44'h008_3333_3333, 52);
    // R3 R9 re-init clears both
    frame("R3", INIT_A, '0, 52);
    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [7:0] a;
      logic [43:0] d;
      int nb, c;
      c = int'($urandom % 4);
      a = (c == 0) ? INIT_A : (c == 3) ? 8'($urandom) : NORM_A;
      d = rnd44();
      if ($urandom % 3 != 0) d = d & ~RSV;
      if (c == 0 && ($urandom % 2 == 0)) d = '0;
      nb = ($urandom % 5 == 0) ? 45 + int'($urandom % 12) : 52;
      frame("R8", a, d, nb);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule